// File: doc/BRIEF.md
# Temperature alert output controller

This block owns the alert pin of a temperature monitor. Each finished conversion hands it a byte of limit-compare results. It keeps a status register, a configuration register and an alert-configure register. From these it decides whether the active-low, open-drain alert line is pulled low. Here, pulled low means that the output enable `alert_oe_o` is high.

Bit 0 of the alert-configure register picks one of two behaviours.

- **Comparator mode:** the pin tracks the most recent compare result and releases on its own once the condition is gone.
- **Interrupt mode:** flags are latched until the host reads the status register. That read clears the flags. When a qualifying flag was set, the read also raises a mask bit in the configuration register, and the pin stays quiet until software writes the mask back to 0.

The busy bit and the open-diode bit never drive the pin and never cause masking.

Top module: `temp_alert_ctrl`

## Requirements
- R1: After reset the status flags, the configuration register (address 09h) and the alert-configure register (address BFh) all read 0. The block is in interrupt mode and `alert_oe_o` is 0.
- R2: Writing BFh with bit 0 = 1 selects comparator mode. Writing bit 0 = 0 selects interrupt mode. Reading BFh returns the written byte.
- R3: In comparator mode `alert_oe_o` is 1 while the latest conversion result has any of bits 6,5,4,3,1,0 set and the mask is 0. It returns to 0 after a conversion without such bits, with no host read.
- R4: On `conv_done_i`, bits 6:0 of `cond_i` are ORed into status bits 6:0. Bit 7 of `cond_i` is ignored. A latched bit stays set through later conversions that no longer report it, until a status read.
- R5: While `addr_i` = 02h, `rdata_o` shows the status before any clear, with bit 7 equal to `busy_i`. A read strobe at 02h clears status bits 6:0 at the next edge.
- R6: In interrupt mode `alert_oe_o` is 1 exactly when any of status bits 6,5,4,3,1,0 is set and configuration bit 7 (mask) is 0.
- R7: In interrupt mode, a status read while any of status bits 6,5,4,3,1,0 is set sets configuration bit 7. A read with none of them set leaves it unchanged.
- R8: While configuration bit 7 is 1, `alert_oe_o` stays 0 in both modes. Only a write of 0 to that bit re-enables the pin.
- R9: When a status read and `conv_done_i` fall in the same cycle, the new flags are kept after the clear.
- R10: In interrupt mode the pin is released at the same edge that applies the status-read clear.
- R11: Status bit 2 (open diode) is latched and reported but never asserts the alert or sets the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cond_i | input | 8 | Compare results of the finished conversion |
| conv_done_i | input | 1 | One-cycle strobe at the end of a conversion |
| busy_i | input | 1 | Converter busy, shown live in status bit 7 |
| rd_i | input | 1 | Register read strobe |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` (combinational) |
| cfg_o | output | 8 | Configuration register; bit 7 is the alert mask |
| alert_oe_o | output | 1 | 1 = drive the alert line low; 0 = release it |

## Verification
The bench builds the block with its default 8-bit register and address widths. It keeps the default register addresses and bit positions, so status, configuration and mode all sit at the offsets stated in the requirements. With the full byte width in place, every status bit can be driven on its own. This covers the two excluded bits, bit 7 of the compare input being discarded, and a status read that coincides with a conversion strobe.

// File: rtl/temp_alert_pkg.sv
package temp_alert_pkg;
  localparam int unsigned REG_W    = 8;
  localparam int unsigned ADDR_W   = 8;
  localparam int unsigned BUSY_BIT = 7;
  localparam int unsigned OPEN_BIT = 2;
  localparam int unsigned MASK_BIT = 7;
  localparam int unsigned MODE_BIT = 0;

  typedef enum logic {
    MODE_INTR = 1'b0,
    MODE_CMP  = 1'b1
  } alert_mode_e;
endpackage

// File: rtl/tac_status_bank.sv
module tac_status_bank #(
  parameter int unsigned REG_W    = 8,
  parameter int unsigned BUSY_BIT = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REG_W-1:0] cond_i,
  input  logic             conv_done_i,
  input  logic             busy_i,
  input  logic             clr_i,
  output logic [REG_W-1:0] status_o,
  output logic [REG_W-1:0] cur_o
);
  for (genvar b = 0; b < REG_W; b++) begin : g_bit
    if (b == BUSY_BIT) begin : g_busy
      assign status_o[b] = busy_i;
      assign cur_o[b]    = 1'b0;
    end else begin : g_flag
      logic flag_q, cur_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          flag_q <= 1'b0;
          cur_q  <= 1'b0;
        end else begin
          // new flags win over the read clear
          flag_q <= (flag_q & ~clr_i) | (conv_done_i & cond_i[b]);
          if (conv_done_i) cur_q <= cond_i[b];
        end
      end
      assign status_o[b] = flag_q;
      assign cur_o[b]    = cur_q;
    end
  end

  assert_clear_on_read_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !conv_done_i) |=> ((status_o & ~(REG_W'(1) << BUSY_BIT)) == '0));
  assert_new_flags_win_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && conv_done_i) |=>
      ((status_o & ~(REG_W'(1) << BUSY_BIT)) == ($past(cond_i) & ~(REG_W'(1) << BUSY_BIT))));
endmodule

// File: rtl/tac_cfg_regs.sv
module tac_cfg_regs #(
  parameter int unsigned    REG_W     = 8,
  parameter int unsigned    ADDR_W    = 8,
  parameter int unsigned    MASK_BIT  = 7,
  parameter logic [ADDR_W-1:0] CFG_ADDR  = 8'h09,
  parameter logic [ADDR_W-1:0] ACFG_ADDR = 8'hBF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              mask_set_i,
  output logic [REG_W-1:0]  cfg_o,
  output logic [REG_W-1:0]  acfg_o
);
  logic wr_cfg, wr_acfg;
  assign wr_cfg  = wr_i && (addr_i == CFG_ADDR);
  assign wr_acfg = wr_i && (addr_i == ACFG_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o  <= '0;
      acfg_o <= '0;
    end else begin
      if (wr_cfg)          cfg_o <= wdata_i;
      else if (mask_set_i) cfg_o[MASK_BIT] <= 1'b1;
      if (wr_acfg)         acfg_o <= wdata_i;
    end
  end

  assert_mask_clear_by_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cfg_o[MASK_BIT]) && !cfg_o[MASK_BIT]) |-> $past(wr_cfg));
endmodule

// File: rtl/tac_alert_drive.sv
module tac_alert_drive
  import temp_alert_pkg::*;
#(
  parameter int unsigned REG_W    = 8,
  parameter int unsigned BUSY_BIT = 7,
  parameter int unsigned OPEN_BIT = 2
) (
  input  alert_mode_e      mode_i,
  input  logic             mask_i,
  input  logic [REG_W-1:0] status_i,
  input  logic [REG_W-1:0] cur_i,
  output logic             qual_o,
  output logic             alert_oe_o
);
  localparam logic [REG_W-1:0] EXCL = (REG_W'(1) << BUSY_BIT) | (REG_W'(1) << OPEN_BIT);
  localparam logic [REG_W-1:0] QUAL = ~EXCL;

  logic cmp_hit;
  assign qual_o  = |(status_i & QUAL);
  assign cmp_hit = |(cur_i & QUAL);

  always_comb begin
    unique case (mode_i)
      MODE_CMP:  alert_oe_o = cmp_hit & ~mask_i;
      default:   alert_oe_o = qual_o & ~mask_i;
    endcase
  end
endmodule

// File: rtl/temp_alert_ctrl.sv
module temp_alert_ctrl
  import temp_alert_pkg::*;
#(
  parameter int unsigned REG_W    = temp_alert_pkg::REG_W,
  parameter int unsigned ADDR_W   = temp_alert_pkg::ADDR_W,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 8'h02,
  parameter logic [ADDR_W-1:0] CFG_ADDR    = 8'h09,
  parameter logic [ADDR_W-1:0] ACFG_ADDR   = 8'hBF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_W-1:0]  cond_i,
  input  logic              conv_done_i,
  input  logic              busy_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic [REG_W-1:0]  cfg_o,
  output logic              alert_oe_o
);
  logic [REG_W-1:0] status, cur, acfg;
  logic             status_rd, mask_set, qual;
  alert_mode_e      mode;

  assign mode      = alert_mode_e'(acfg[MODE_BIT]);
  assign status_rd = rd_i && (addr_i == STATUS_ADDR);
  assign mask_set  = status_rd && (mode == MODE_INTR) && qual;

  tac_status_bank #(.REG_W(REG_W), .BUSY_BIT(BUSY_BIT)) u_status (
    .clk_i, .rst_ni, .cond_i, .conv_done_i, .busy_i,
    .clr_i(status_rd), .status_o(status), .cur_o(cur)
  );

  tac_cfg_regs #(.REG_W(REG_W), .ADDR_W(ADDR_W), .MASK_BIT(MASK_BIT),
                 .CFG_ADDR(CFG_ADDR), .ACFG_ADDR(ACFG_ADDR)) u_cfg (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i,
    .mask_set_i(mask_set), .cfg_o, .acfg_o(acfg)
  );

  tac_alert_drive #(.REG_W(REG_W), .BUSY_BIT(BUSY_BIT), .OPEN_BIT(OPEN_BIT)) u_drive (
    .mode_i(mode), .mask_i(cfg_o[MASK_BIT]), .status_i(status), .cur_i(cur),
    .qual_o(qual), .alert_oe_o
  );

  always_comb begin
    if (addr_i == STATUS_ADDR)    rdata_o = status;
    else if (addr_i == CFG_ADDR)  rdata_o = cfg_o;
    else if (addr_i == ACFG_ADDR) rdata_o = acfg;
    else                          rdata_o = '0;
  end

  assert_mask_on_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_rd && !wr_i && mode == MODE_INTR && qual) |=> cfg_o[MASK_BIT]);
  assert_masked_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_o[MASK_BIT] |-> !alert_oe_o);
  assert_release_on_read_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_rd && !wr_i && !conv_done_i && mode == MODE_INTR) |=>
      (!alert_oe_o || $past(wr_i)));
  assert_open_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_INTR && !qual) |-> !alert_oe_o);
endmodule

// File: tb/temp_alert_ctrl_tb.sv
module temp_alert_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cond = '0, addr = '0, wdata = '0;
  logic       conv_done = 1'b0, busy = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [7:0] rdata, cfg;
  logic       alert_oe;
  int         checks = 0, errors = 0;
  logic [7:0] got;

  always #10 clk = ~clk;

  temp_alert_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cond_i(cond), .conv_done_i(conv_done), .busy_i(busy),
    .rd_i(rd), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .cfg_o(cfg), .alert_oe_o(alert_oe)
  );

  localparam logic [7:0] QUAL = 8'h7B;
  localparam int         NV   = 7;
  localparam logic [7:0] VEC [NV] = '{8'h01, 8'h04, 8'h40, 8'h84, 8'h2A, 8'h00, 8'h12};

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic conv(input logic [7:0] c);
    @(negedge clk); cond = c; conv_done = 1'b1;
    @(negedge clk); conv_done = 1'b0; cond = '0;
  endtask

  task automatic rd_status(output logic [7:0] v);
    @(negedge clk); addr = 8'h02; rd = 1'b1;
    #1 v = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic peek(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; #1 v = rdata;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    peek(8'h02, got); chk("R1 status", got, 8'h00);
    peek(8'h09, got); chk("R1 cfg", got, 8'h00);
    peek(8'hBF, got); chk("R1 acfg", got, 8'h00);
    chk("R1 alert", {7'd0, alert_oe}, 8'h00);

    // table walk, interrupt mode: R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      logic [7:0] exp_st;
      logic       hit;
      exp_st = VEC[i] & 8'h7F;
      hit    = |(VEC[i] & QUAL);
      conv(VEC[i]);
      chk("R6 alert after conv", {7'd0, alert_oe}, {7'd0, hit});
      rd_status(got);
      chk("R5 R4 status read", got, exp_st);
      @(negedge clk);
      chk("R7 mask after read", {7'd0, cfg[7]}, {7'd0, hit});
      chk("R10 alert after read", {7'd0, alert_oe}, 8'h00);
      wr_reg(8'h09, 8'h00);
    end

    // R4 flags persist until read
    conv(8'h08); conv(8'h00);
    chk("R4 persist alert", {7'd0, alert_oe}, 8'h01);
    // R10 release at the clear edge
    @(negedge clk); addr = 8'h02; rd = 1'b1;
    #1 chk("R10 before edge", {7'd0, alert_oe}, 8'h01);
    @(negedge clk); rd = 1'b0;
    chk("R10 after edge", {7'd0, alert_oe}, 8'h00);
    // R8 mask holds through new flags and a write of 1
    conv(8'h01);
    chk("R8 masked", {7'd0, alert_oe}, 8'h00);
    wr_reg(8'h09, 8'h80);
    chk("R8 write one keeps mask", {7'd0, alert_oe}, 8'h00);
    wr_reg(8'h09, 8'h00);
    chk("R8 write zero reenables", {7'd0, alert_oe}, 8'h01);

    // R9 read and conversion in the same cycle
    @(negedge clk); addr = 8'h02; rd = 1'b1; cond = 8'h08; conv_done = 1'b1;
    #1 chk("R9 pre-clear data", rdata, 8'h01);
    @(negedge clk); rd = 1'b0; conv_done = 1'b0; cond = '0;
    chk("R9 mask set", {7'd0, cfg[7]}, 8'h01);
    peek(8'h02, got); chk("R9 new flag kept", got, 8'h08);
    wr_reg(8'h09, 8'h00);
    chk("R9 alert from new flag", {7'd0, alert_oe}, 8'h01);
    rd_status(got);
    wr_reg(8'h09, 8'h00);

    // R11 open bit only
    conv(8'h04);
    chk("R11 open no alert", {7'd0, alert_oe}, 8'h00);
    rd_status(got);
    chk("R11 open reported", got, 8'h04);
    @(negedge clk);
    chk("R11 no mask", {7'd0, cfg[7]}, 8'h00);

    // R5 busy live
    busy = 1'b1;
    peek(8'h02, got); chk("R5 busy bit", got, 8'h80);
    busy = 1'b0;

    // R2 R3 comparator mode
    wr_reg(8'hBF, 8'h01);
    peek(8'hBF, got); chk("R2 acfg readback", got, 8'h01);
    conv(8'h10);
    chk("R3 cmp assert", {7'd0, alert_oe}, 8'h01);
    conv(8'h00);
    chk("R3 cmp self release", {7'd0, alert_oe}, 8'h00);
    conv(8'h20);
    rd_status(got);
    chk("R4 cmp status latched", got, 8'h30);
    @(negedge clk);
    chk("R7 no mask in cmp", {7'd0, cfg[7]}, 8'h00);
    chk("R3 cmp alert after read", {7'd0, alert_oe}, 8'h01);
    wr_reg(8'h09, 8'h80);
    chk("R8 mask in cmp", {7'd0, alert_oe}, 8'h00);
    wr_reg(8'h09, 8'h00);
    wr_reg(8'hBF, 8'h00);
    chk("R2 back to intr", {7'd0, alert_oe}, 8'h00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule